// File: doc/BRIEF.md
# Standby Power Rail Sequencer

This controller sits on the platform side of a board and brings up the always-on supplies of a system-on-chip. It switches on the 1.8 V and 1.0 V standby regulators in a selectable order. It switches on the 3.3 V standby regulator only once both lower rails report good. It then holds the resume-well reset for a programmed interval before releasing it. The interval is measured from the point where every standby rail is good and the Ethernet reference clock is stable. A separate path releases the RTC-well reset a programmed time after the RTC rail comes good.

The power-ok strap output stays driven through a short window after the resume reset lets go. The core power-ok output is held low for the whole standby phase. When the chip lowers its sleep-S4/S5 output after the resume release, the sequencer reports that soft-off has been reached.

Every power-good, clock-stable and sleep input passes through a two-flop synchronizer before the state machine sees it. A rail that never reports good within a step timeout causes a fault. A rail that drops after it was seen good also causes a fault. The fault turns every regulator off, pulls the resets back low and stays latched until the top-level reset. All delays are parameters counted in clock cycles.

Top module: `stby_rail_seq`

## Requirements
- R1: `order_mode` is sampled when reset is released. Value 0 enables the 1.8 V rail first and the 1.0 V rail only after `pg_1v8` is good. Value 1 reverses that order. Values 2 and 3 enable both rails in the same cycle.
- R2: `en_3v3` stays low until both `pg_1v8` and `pg_1v0` have been seen good.
- R3: `resume_rst_n` is low throughout the rail sequence. It rises no sooner than T_RSM cycles after all three standby rails are good and `refclk_ok` is high. If `refclk_ok` falls during that wait, the count starts over.
- R4: `core_pwrok` is low at all times.
- R5: `rtc_rst_n` rises no sooner than T_RTC cycles after `pg_rtc` goes high. It returns low when `pg_rtc` falls.
- R6: `strap_drv` is high from reset. It stays high for at least T_STRAP cycles after `resume_rst_n` rises, then falls.
- R7: `soft_off` rises when `slp_s45_n` is low after the strap window ends. A low `slp_s45_n` before the resume release does not set `soft_off` early.
- R8: If a rail's power-good falls after it was seen good, `fault` rises and all enables go low. `resume_rst_n` and `rtc_rst_n` go low, and the state stays latched until `rst_n`.
- R9: If a waited-for rail (or the clock-stable flag) is not good within T_TMO cycles of its step starting, `fault` rises with the same effects as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_mode | input | 2 | Lower-rail order: 0 = 1.8 V first, 1 = 1.0 V first, 2/3 = together |
| pg_rtc | input | 1 | RTC rail good |
| pg_1v8 | input | 1 | 1.8 V standby rail good |
| pg_1v0 | input | 1 | 1.0 V standby rail good |
| pg_3v3 | input | 1 | 3.3 V standby rail good |
| refclk_ok | input | 1 | Ethernet reference clock stable |
| slp_s45_n | input | 1 | Active-low sleep-S4/S5 indication from the chip |
| en_1v8 | output | 1 | 1.8 V regulator enable |
| en_1v0 | output | 1 | 1.0 V regulator enable |
| en_3v3 | output | 1 | 3.3 V regulator enable |
| rtc_rst_n | output | 1 | Active-low RTC-well reset |
| resume_rst_n | output | 1 | Active-low resume-well reset |
| strap_drv | output | 1 | Power-ok strap drive window |
| core_pwrok | output | 1 | Core power-ok, held low |
| soft_off | output | 1 | Soft-off state reached |
| fault | output | 1 | Latched sequencing fault |

## Verification
The hardest case to reach from the ports is a loss of the reference clock partway through the resume hold. In that case the release must be timed from the clock's return, not from the first time the rails were good. The stimulus reaches this by answering each enable with its power-good, then dropping `refclk_ok` for a few cycles halfway through the hold. It then measures the release against the return of the clock. A second hard case is a sleep indication that arrives too early: the same flow drives `slp_s45_n` low before any rail is on and confirms that `soft_off` waits for the strap window to close.

// File: rtl/stby_seq_pkg.sv
package stby_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_HIGH,
    ST_HOLD,
    ST_STRAP,
    ST_S5WAIT,
    ST_SOFTOFF,
    ST_FAULT
  } seq_st_e;

  // bit positions of the synchronized input bus
  localparam int unsigned SI_RTC = 0;
  localparam int unsigned SI_1V8 = 1;
  localparam int unsigned SI_1V0 = 2;
  localparam int unsigned SI_3V3 = 3;
  localparam int unsigned SI_CLK = 4;
  localparam int unsigned SI_SLP = 5;
  localparam int unsigned SI_W   = 6;

  localparam logic [1:0] ORD_1V8_FIRST = 2'd0;
  localparam logic [1:0] ORD_1V0_FIRST = 2'd1;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/stby_rst_sync.sv
module stby_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/stby_sync_bus.sv
module stby_sync_bus #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d[i]};
    end
    assign q[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/stby_cycle_timer.sv
module stby_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign done   = (cnt_q >= lim);
  assign cnt_ce = clr || (en && !done);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stby_rtc_gate.sv
module stby_rtc_gate #(
  parameter int unsigned T_RTC = 225000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_good,
  input  logic fault,
  output logic rtc_rst_n
);
  localparam int unsigned W   = $clog2(T_RTC + 1);
  localparam logic [W-1:0] LIM = W'(T_RTC - 1);

  logic rel_q, rel_d, tmr_done;

  stby_cycle_timer #(.W(W)) u_rtc_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!rtc_good),
    .en   (!rel_q),
    .lim  (LIM),
    .done (tmr_done)
  );

  assign rel_d = rtc_good && (rel_q || tmr_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_d;
  end

  assign rtc_rst_n = rel_q && !fault;
endmodule

// File: rtl/stby_rail_fsm.sv
module stby_rail_fsm
  import stby_seq_pkg::*;
#(
  parameter int unsigned T_RSM   = 250000,
  parameter int unsigned T_STRAP = 10,
  parameter int unsigned T_TMO   = 1048576
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       pg_1v8,
  input  logic       pg_1v0,
  input  logic       pg_3v3,
  input  logic       refclk_ok,
  input  logic       slp_n,
  output logic       en_1v8,
  output logic       en_1v0,
  output logic       en_3v3,
  output logic       resume_rst_n,
  output logic       strap_drv,
  output logic       soft_off,
  output logic       fault
);
  localparam int unsigned TMAX = max3(T_RSM, T_STRAP, T_TMO);
  localparam int unsigned W    = $clog2(TMAX + 1);
  localparam logic [W-1:0] LIM_RSM   = W'(T_RSM - 1);
  localparam logic [W-1:0] LIM_STRAP = W'(T_STRAP - 1);
  localparam logic [W-1:0] LIM_TMO   = W'(T_TMO - 1);

  seq_st_e      st_q, st_d;
  logic [1:0]   mode_q;
  logic         mode_ce;
  logic [2:0]   seen_q, seen_d, pg_vec, en_vec;
  logic [W-1:0] lim;
  logic         tmr_clr, tmr_done;
  logic         first_ok, both_ok, drop;

  // lower-rail readiness for the first step
  always_comb begin
    case (mode_q)
      ORD_1V8_FIRST: first_ok = pg_1v8;
      ORD_1V0_FIRST: first_ok = pg_1v0;
      default:       first_ok = pg_1v8 && pg_1v0;
    endcase
  end
  assign both_ok = pg_1v8 && pg_1v0;

  // a rail seen good while enabled must stay good
  assign pg_vec = {pg_3v3, pg_1v0, pg_1v8};
  assign en_vec = {en_3v3, en_1v0, en_1v8};
  assign seen_d = seen_q | (pg_vec & en_vec);
  assign drop   = |(seen_q & ~pg_vec);

  // next state
  always_comb begin
    st_d = st_q;
    lim  = LIM_TMO;
    case (st_q)
      ST_IDLE:   st_d = ST_FIRST;
      ST_FIRST: begin
        if (mode_q[1]) begin
          if (both_ok)       st_d = ST_HIGH;
          else if (tmr_done) st_d = ST_FAULT;
        end else begin
          if (first_ok)      st_d = ST_SECOND;
          else if (tmr_done) st_d = ST_FAULT;
        end
      end
      ST_SECOND: begin
        if (both_ok)         st_d = ST_HIGH;
        else if (tmr_done)   st_d = ST_FAULT;
      end
      ST_HIGH: begin
        if (pg_3v3 && refclk_ok) st_d = ST_HOLD;
        else if (tmr_done)       st_d = ST_FAULT;
      end
      ST_HOLD: begin
        lim = LIM_RSM;
        if (tmr_done && refclk_ok) st_d = ST_STRAP;
      end
      ST_STRAP: begin
        lim = LIM_STRAP;
        if (tmr_done) st_d = ST_S5WAIT;
      end
      ST_S5WAIT: if (!slp_n) st_d = ST_SOFTOFF;
      default:   st_d = st_q;
    endcase
    if (drop && (st_q != ST_FAULT) && (st_q != ST_IDLE)) st_d = ST_FAULT;
  end

  assign tmr_clr = (st_d != st_q) || ((st_q == ST_HOLD) && !refclk_ok);
  assign mode_ce = (st_q == ST_IDLE);

  stby_cycle_timer #(.W(W)) u_step_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .en   (1'b1),
    .lim  (lim),
    .done (tmr_done)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      seen_q <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= ORD_1V8_FIRST;
    else if (mode_ce) mode_q <= mode;
  end

  // output decode from the state register
  always_comb begin
    en_1v8       = 1'b0;
    en_1v0       = 1'b0;
    en_3v3       = 1'b0;
    resume_rst_n = 1'b0;
    strap_drv    = 1'b1;
    soft_off     = 1'b0;
    fault        = 1'b0;
    case (st_q)
      ST_FIRST: begin
        en_1v8 = (mode_q != ORD_1V0_FIRST);
        en_1v0 = (mode_q != ORD_1V8_FIRST);
      end
      ST_SECOND: begin
        en_1v8 = 1'b1;
        en_1v0 = 1'b1;
      end
      ST_HIGH, ST_HOLD: begin
        en_1v8 = 1'b1;
        en_1v0 = 1'b1;
        en_3v3 = 1'b1;
      end
      ST_STRAP: begin
        en_1v8       = 1'b1;
        en_1v0       = 1'b1;
        en_3v3       = 1'b1;
        resume_rst_n = 1'b1;
      end
      ST_S5WAIT, ST_SOFTOFF: begin
        en_1v8       = 1'b1;
        en_1v0       = 1'b1;
        en_3v3       = 1'b1;
        resume_rst_n = 1'b1;
        strap_drv    = 1'b0;
        soft_off     = (st_q == ST_SOFTOFF);
      end
      ST_FAULT: fault = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/stby_rail_seq.sv
module stby_rail_seq
  import stby_seq_pkg::*;
#(
  parameter int unsigned T_RSM       = 250000,
  parameter int unsigned T_RTC       = 225000,
  parameter int unsigned T_STRAP     = 10,
  parameter int unsigned T_TMO       = 1048576,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] order_mode,
  input  logic       pg_rtc,
  input  logic       pg_1v8,
  input  logic       pg_1v0,
  input  logic       pg_3v3,
  input  logic       refclk_ok,
  input  logic       slp_s45_n,
  output logic       en_1v8,
  output logic       en_1v0,
  output logic       en_3v3,
  output logic       rtc_rst_n,
  output logic       resume_rst_n,
  output logic       strap_drv,
  output logic       core_pwrok,
  output logic       soft_off,
  output logic       fault
);
  logic            rst_int_n;
  logic [SI_W-1:0] raw, syn;

  assign raw = {slp_s45_n, refclk_ok, pg_3v3, pg_1v0, pg_1v8, pg_rtc};

  stby_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  stby_sync_bus #(.W(SI_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (raw),
    .q    (syn)
  );

  stby_rail_fsm #(.T_RSM(T_RSM), .T_STRAP(T_STRAP), .T_TMO(T_TMO)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode        (order_mode),
    .pg_1v8      (syn[SI_1V8]),
    .pg_1v0      (syn[SI_1V0]),
    .pg_3v3      (syn[SI_3V3]),
    .refclk_ok   (syn[SI_CLK]),
    .slp_n       (syn[SI_SLP]),
    .en_1v8      (en_1v8),
    .en_1v0      (en_1v0),
    .en_3v3      (en_3v3),
    .resume_rst_n(resume_rst_n),
    .strap_drv   (strap_drv),
    .soft_off    (soft_off),
    .fault       (fault)
  );

  stby_rtc_gate #(.T_RTC(T_RTC)) u_rtc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rtc_good (syn[SI_RTC]),
    .fault    (fault),
    .rtc_rst_n(rtc_rst_n)
  );

  assign core_pwrok = 1'b0;
endmodule

// File: rtl/stby_rail_seq_chk.sv
module stby_rail_seq_chk #(
  parameter int unsigned T_STRAP = 10
) (
  input logic clk,
  input logic rst_n,
  input logic s_rtc,
  input logic s_1v8,
  input logic s_1v0,
  input logic en_1v8,
  input logic en_1v0,
  input logic en_3v3,
  input logic rtc_rst_n,
  input logic resume_rst_n,
  input logic strap_drv,
  input logic soft_off,
  input logic fault
);
  localparam int unsigned CW = $clog2(T_STRAP + 1);
  localparam logic [CW-1:0] CMAX = CW'(T_STRAP);

  logic [CW-1:0] rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rel_cnt <= '0;
    else if (!resume_rst_n) rel_cnt <= '0;
    else if (rel_cnt < CMAX) rel_cnt <= rel_cnt + 1'b1;
  end

  // R2
  high_rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_3v3) |-> $past(s_1v8 && s_1v0));

  // R3
  resume_after_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_rst_n |-> (en_1v8 && en_1v0 && en_3v3));

  // R5
  rtc_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_rst_n) |-> $past(s_rtc));

  // R6
  strap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strap_drv) |-> (rel_cnt >= CMAX));

  // R7
  soft_off_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off |-> (resume_rst_n && !strap_drv));

  // R8
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R8
  fault_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!en_1v8 && !en_1v0 && !en_3v3 && !resume_rst_n && !rtc_rst_n));
endmodule

bind stby_rail_seq stby_rail_seq_chk #(.T_STRAP(T_STRAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_rtc       (syn[0]),
  .s_1v8       (syn[1]),
  .s_1v0       (syn[2]),
  .en_1v8      (en_1v8),
  .en_1v0      (en_1v0),
  .en_3v3      (en_3v3),
  .rtc_rst_n   (rtc_rst_n),
  .resume_rst_n(resume_rst_n),
  .strap_drv   (strap_drv),
  .soft_off    (soft_off),
  .fault       (fault)
);

// File: tb/stby_rail_seq_bench.sv
`timescale 1ns/1ps
module stby_rail_seq_bench;
  localparam int T_RSM   = 40;
  localparam int T_RTC   = 30;
  localparam int T_STRAP = 5;
  localparam int T_TMO   = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] order_mode;
  logic pg_rtc, pg_1v8, pg_1v0, pg_3v3, refclk_ok, slp_s45_n;
  logic en_1v8, en_1v0, en_3v3, rtc_rst_n, resume_rst_n, strap_drv, core_pwrok, soft_off, fault;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  stby_rail_seq #(.T_RSM(T_RSM), .T_RTC(T_RTC), .T_STRAP(T_STRAP), .T_TMO(T_TMO)) u_stby_rail_seq (
    .clk(clk), .rst_n(rst_n), .order_mode(order_mode), .pg_rtc(pg_rtc), .pg_1v8(pg_1v8),
    .pg_1v0(pg_1v0), .pg_3v3(pg_3v3), .refclk_ok(refclk_ok), .slp_s45_n(slp_s45_n),
    .en_1v8(en_1v8), .en_1v0(en_1v0), .en_3v3(en_3v3), .rtc_rst_n(rtc_rst_n),
    .resume_rst_n(resume_rst_n), .strap_drv(strap_drv), .core_pwrok(core_pwrok),
    .soft_off(soft_off), .fault(fault)
  );

  // row: {mode[1:0], expected first enables {en_1v0,en_1v8}, refclk glitch, early sleep}
  localparam logic [5:0] VEC [0:4] = '{
    {2'd0, 2'b01, 1'b0, 1'b0},
    {2'd1, 2'b10, 1'b0, 1'b0},
    {2'd2, 2'b11, 1'b0, 1'b0},
    {2'd3, 2'b11, 1'b1, 1'b0},
    {2'd0, 2'b01, 1'b1, 1'b1}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_n = 1'b0;
    order_mode = mode;
    pg_rtc = 0; pg_1v8 = 0; pg_1v0 = 0; pg_3v3 = 0; refclk_ok = 0; slp_s45_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bringup(input logic [1:0] mode, input logic [1:0] exp_first,
                         input logic glitch, input logic early);
    int n;
    do_reset(mode);
    if (early) slp_s45_n = 1'b0;
    n = 0;
    while (!(en_1v8 || en_1v0) && n < 20) begin @(negedge clk); n++; end
    check({en_1v0, en_1v8} == exp_first, "R1 first enables", {en_1v0, en_1v8}, exp_first);
    repeat (5) @(negedge clk);
    check({en_1v0, en_1v8} == exp_first, "R1 order held without pg", {en_1v0, en_1v8}, exp_first);
    check(en_3v3 == 1'b0, "R2 3v3 off before lower rails", en_3v3, 0);
    pg_1v8 = en_1v8;
    pg_1v0 = en_1v0;
    if (!(en_1v8 && en_1v0)) begin
      n = 0;
      while (!(en_1v8 && en_1v0) && n < 20) begin @(negedge clk); n++; end
      check(en_1v8 && en_1v0, "R1 second rail follows", en_1v8 && en_1v0, 1);
      check(en_3v3 == 1'b0, "R2 3v3 off with one rail good", en_3v3, 0);
      pg_1v8 = 1'b1;
      pg_1v0 = 1'b1;
    end
    n = 0;
    while (!en_3v3 && n < 20) begin @(negedge clk); n++; end
    check(en_3v3 == 1'b1, "R2 3v3 after both good", en_3v3, 1);
    check(resume_rst_n == 1'b0, "R3 resume held during sequence", resume_rst_n, 0);
    check(core_pwrok == 1'b0, "R4 core power-ok low", core_pwrok, 0);
    pg_3v3 = 1'b1;
    refclk_ok = 1'b1;
    if (glitch) begin
      repeat (T_RSM / 2) @(negedge clk);
      check(resume_rst_n == 1'b0, "R3 resume held mid-wait", resume_rst_n, 0);
      refclk_ok = 1'b0;
      repeat (3) @(negedge clk);
      refclk_ok = 1'b1;
    end
    n = 0;
    while (!resume_rst_n && n < T_RSM + 50) begin @(negedge clk); n++; end
    check(n >= T_RSM && n <= T_RSM + 6, "R3 resume release delay", n, T_RSM);
    check(soft_off == 1'b0, "R7 no soft-off at release", soft_off, 0);
    check(strap_drv == 1'b1, "R6 strap driven at release", strap_drv, 1);
    n = 0;
    while (strap_drv && n < 50) begin @(negedge clk); n++; end
    check(n >= T_STRAP && n <= T_STRAP + 2, "R6 strap window", n, T_STRAP);
    if (!early) begin
      check(soft_off == 1'b0, "R7 no soft-off while sleep high", soft_off, 0);
      slp_s45_n = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(soft_off == 1'b1, "R7 soft-off reached", soft_off, 1);
    check(core_pwrok == 1'b0, "R4 core power-ok low in soft-off", core_pwrok, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    // reset state, sampled while reset is held
    rst_n = 1'b0;
    order_mode = 2'd0;
    pg_rtc = 0; pg_1v8 = 0; pg_1v0 = 0; pg_3v3 = 0; refclk_ok = 0; slp_s45_n = 1;
    repeat (3) @(negedge clk);
    check({en_1v8, en_1v0, en_3v3} == 3'b000, "R2 enables off in reset", {en_1v8, en_1v0, en_3v3}, 0);
    check(resume_rst_n == 1'b0, "R3 resume low in reset", resume_rst_n, 0);
    check(rtc_rst_n == 1'b0, "R5 rtc low in reset", rtc_rst_n, 0);
    check(strap_drv == 1'b1, "R6 strap high in reset", strap_drv, 1);
    check(core_pwrok == 1'b0, "R4 core low in reset", core_pwrok, 0);
    check(soft_off == 1'b0 && fault == 1'b0, "R8 no flags in reset", {soft_off, fault}, 0);

    // table-driven bring-up
    for (int i = 0; i < 5; i++) begin
      bringup(VEC[i][5:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R5 rtc release and drop
    do_reset(2'd0);
    pg_rtc = 1'b1;
    n = 0;
    while (!rtc_rst_n && n < T_RTC + 50) begin @(negedge clk); n++; end
    check(n >= T_RTC && n <= T_RTC + 6, "R5 rtc release delay", n, T_RTC);
    pg_rtc = 1'b0;
    repeat (4) @(negedge clk);
    check(rtc_rst_n == 1'b0, "R5 rtc reasserted on drop", rtc_rst_n, 0);

    // R8 rail drop after full bring-up
    bringup(2'd0, 2'b01, 1'b0, 1'b0);
    pg_1v0 = 1'b0;
    repeat (4) @(negedge clk);
    check(fault == 1'b1, "R8 fault on rail drop", fault, 1);
    check({en_1v8, en_1v0, en_3v3} == 3'b000, "R8 enables off", {en_1v8, en_1v0, en_3v3}, 0);
    check(resume_rst_n == 1'b0 && soft_off == 1'b0, "R8 resume reasserted", {resume_rst_n, soft_off}, 0);
    pg_1v0 = 1'b1;
    repeat (10) @(negedge clk);
    check(fault == 1'b1, "R8 fault latched", fault, 1);

    // R9 step timeout
    do_reset(2'd0);
    n = 0;
    while (!en_1v8 && n < 20) begin @(negedge clk); n++; end
    repeat (T_TMO - 3) @(negedge clk);
    check(fault == 1'b0, "R9 no fault before timeout", fault, 0);
    repeat (6) @(negedge clk);
    check(fault == 1'b1, "R9 fault after timeout", fault, 1);
    check(en_1v8 == 1'b0, "R9 enable dropped", en_1v8, 0);

    finish_run();
  end
endmodule